// File: doc/BRIEF.md
# Tear-free byte access bridge for wide registers

This block sits between a byte-wide bus and a set of peripheral registers that are two bytes wide, such as a capture counter snapshot. A 16-bit value that keeps changing can be read as two bytes without tearing, and it can be written as one word. The block does this with a single holding byte that every wide register shares.

Reads go low byte first. A low-byte read returns the live low byte and, at the same clock edge, freezes the live high byte into the holding byte. The later high-byte read returns the frozen byte. Writes go high byte first. A high-byte write only loads the holding byte. The low-byte write then issues a one-cycle word write to the peripheral, built from the holding byte and the new low byte. A per-register write-allow input blocks that word write, for example while the register's mode makes it read-only.

Top module: `wide_reg_bridge`

## Requirements
- R1: A read strobe at the low address of register i (byte address 2*i) returns the live low byte of register i on `bus_rdata` in the same cycle.
- R2: At the clock edge that ends a low-address read of register i, the holding byte takes the live high byte of register i as it was in that cycle.
- R3: A read at a high address (2*i+1) returns the holding byte, not the live high byte, and leaves the holding byte unchanged.
- R4: A write at a high address loads `bus_wdata` into the holding byte and causes no peripheral write strobe.
- R5: A write at the low address of register i while `wr_allow[i]` is 1 raises `per_wstb` as the one-hot code with only bit i set, in the cycle after the write, for exactly one cycle. `per_wdata` then carries the holding byte in its upper byte and the written byte in its lower byte.
- R6: A low-address write to register i while `wr_allow[i]` is 0 is ignored. No strobe is raised, `per_wdata` keeps its old value and the holding byte is unchanged.
- R7: The holding byte is shared by all registers, so a low read or high write aimed at one register changes what a later high read or low write of another register sees.
- R8: After reset the holding byte, `per_wstb` and `per_wdata` are all zero.
- R9: Byte addresses at or above 2*NUM_REGS decode to no register. Reads there return 0, and writes there change neither the holding byte nor the peripheral outputs.
- R10: At most one bit of `per_wstb` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bit 0 selects the high byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe; has priority over a read in the same cycle |
| bus_wdata | input | BYTE_W | Write byte |
| bus_rdata | output | BYTE_W | Read byte, valid while the read strobe is high |
| live_val | input | NUM_REGS*2*BYTE_W | Current value of each wide register, register i at bits [i*2*BYTE_W +: 2*BYTE_W] |
| wr_allow | input | NUM_REGS | Per-register permission to accept a word write |
| per_wdata | output | 2*BYTE_W | Word written to the peripheral |
| per_wstb | output | NUM_REGS | One-cycle write strobe per register |

## Verification
The bench builds the block with three registers, 8-bit bytes and a 3-bit address. That leaves two unmapped addresses (6 and 7) for the decode checks, and gives enough registers for accesses to one register to disturb the shared holding byte seen by another. For every register the bench sweeps a set of computed live values and write bytes, and it alternates the write-allow bit so that both accepted and blocked word writes are covered. The live high byte is changed between the low and high reads, so a design that returns the live byte on a high read shows up as a mismatch.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

   typedef enum logic [2:0] {
      ACC_NONE  = 3'd0,
      ACC_RD_LO = 3'd1,
      ACC_RD_HI = 3'd2,
      ACC_WR_LO = 3'd3,
      ACC_WR_HI = 3'd4
   } acc_t;

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
   import wrb_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int NUM_REGS = 3,
   parameter int BYTE_W   = 8
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          rd,
   input  logic                          wr,
   input  logic [NUM_REGS*2*BYTE_W-1:0]  live,
   output acc_t                          acc,
   output logic [NUM_REGS-1:0]           sel,
   output logic [BYTE_W-1:0]             lo_byte,
   output logic [BYTE_W-1:0]             hi_byte
);
   localparam int IDX_W  = ADDR_W - 1;
   localparam int WORD_W = 2 * BYTE_W;

   logic hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign sel[i] = (addr[ADDR_W-1:1] == IDX_W'(i));
   end

   assign hit = |sel;

   always_comb begin
      lo_byte = '0;
      hi_byte = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (sel[i]) begin
            lo_byte = lo_byte | live[i*WORD_W +: BYTE_W];
            hi_byte = hi_byte | live[i*WORD_W+BYTE_W +: BYTE_W];
         end
      end
   end

   always_comb begin
      acc = ACC_NONE;
      if (hit) begin
         if (wr)      acc = addr[0] ? ACC_WR_HI : ACC_WR_LO;
         else if (rd) acc = addr[0] ? ACC_RD_HI : ACC_RD_LO;
      end
   end

   always_comb begin
      assert_sel_onehot_R9: assert ($onehot0(sel));
   end

endmodule

// File: rtl/wrb_hold.sv
module wrb_hold
   import wrb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_t              acc,
   input  logic [BYTE_W-1:0] hi_live,
   input  logic [BYTE_W-1:0] wbyte,
   output logic [BYTE_W-1:0] hold_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else begin
         case (acc)
            ACC_RD_LO: hold_q <= hi_live;
            ACC_WR_HI: hold_q <= wbyte;
            default:   hold_q <= hold_q;
         endcase
      end
   end

   assert_hold_lowwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_WR_LO) |=> $stable(hold_q));

   assert_hold_hird_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_RD_HI) |=> $stable(hold_q));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_NONE) |=> $stable(hold_q));

endmodule

// File: rtl/wrb_launch.sv
module wrb_launch
   import wrb_pkg::*;
#(
   parameter int NUM_REGS = 3,
   parameter int BYTE_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  acc_t                  acc,
   input  logic [NUM_REGS-1:0]   sel,
   input  logic [NUM_REGS-1:0]   allow,
   input  logic [BYTE_W-1:0]     hold_q,
   input  logic [BYTE_W-1:0]     wbyte,
   output logic [2*BYTE_W-1:0]   per_wdata,
   output logic [NUM_REGS-1:0]   per_wstb
);
   logic                fire;
   logic [NUM_REGS-1:0] go;

   assign fire = (acc == ACC_WR_LO);
   assign go   = sel & allow & {NUM_REGS{fire}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_wstb  <= '0;
         per_wdata <= '0;
      end else begin
         per_wstb <= go;
         if (|go) per_wdata <= {hold_q, wbyte};
      end
   end

   assert_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(per_wstb));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
      assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && sel[i] && !allow[i]) |=> !per_wstb[i]);
   end

   assert_data_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|go) |=> $stable(per_wdata));

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrb_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int NUM_REGS = 3,
   parameter int BYTE_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_rd,
   input  logic                          bus_wr,
   input  logic [BYTE_W-1:0]             bus_wdata,
   output logic [BYTE_W-1:0]             bus_rdata,
   input  logic [NUM_REGS*2*BYTE_W-1:0]  live_val,
   input  logic [NUM_REGS-1:0]           wr_allow,
   output logic [2*BYTE_W-1:0]           per_wdata,
   output logic [NUM_REGS-1:0]           per_wstb
);
   localparam int MAP_SPAN = 2 ** (ADDR_W - 1);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("wide_reg_bridge: ADDR_W must be at least 2");
   end
   if (NUM_REGS < 1 || NUM_REGS > MAP_SPAN) begin : g_bad_regs
      $error("wide_reg_bridge: NUM_REGS must fit the address space");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("wide_reg_bridge: BYTE_W must be positive");
   end

   acc_t                acc;
   logic [NUM_REGS-1:0] sel;
   logic [BYTE_W-1:0]   lo_byte;
   logic [BYTE_W-1:0]   hi_byte;
   logic [BYTE_W-1:0]   hold_q;

   wrb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) i_decode (
      .addr    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .live    (live_val),
      .acc     (acc),
      .sel     (sel),
      .lo_byte (lo_byte),
      .hi_byte (hi_byte)
   );

   wrb_hold #(.BYTE_W(BYTE_W)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .hi_live (hi_byte),
      .wbyte   (bus_wdata),
      .hold_q  (hold_q)
   );

   wrb_launch #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) i_launch (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .sel       (sel),
      .allow     (wr_allow),
      .hold_q    (hold_q),
      .wbyte     (bus_wdata),
      .per_wdata (per_wdata),
      .per_wstb  (per_wstb)
   );

   always_comb begin
      case (acc)
         ACC_RD_LO: bus_rdata = lo_byte;
         ACC_RD_HI: bus_rdata = hold_q;
         default:   bus_rdata = '0;
      endcase
   end

   assert_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_RD_LO) |=> (hold_q == $past(hi_byte)));

   assert_hiwr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_WR_HI) |=> (hold_q == $past(bus_wdata)) && (per_wstb == '0));

   assert_stb_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|per_wstb) |-> $past(bus_wr && !bus_addr[0]));

endmodule

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
   localparam int ADDR_W = 3;
   localparam int NREG   = 3;
   localparam int BW     = 8;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [ADDR_W-1:0]      bus_addr = '0;
   logic                   bus_rd = 1'b0;
   logic                   bus_wr = 1'b0;
   logic [BW-1:0]          bus_wdata = '0;
   logic [BW-1:0]          bus_rdata;
   logic [NREG*2*BW-1:0]   live_val = '0;
   logic [NREG-1:0]        wr_allow = '1;
   logic [2*BW-1:0]        per_wdata;
   logic [NREG-1:0]        per_wstb;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   wide_reg_bridge #(.ADDR_W(ADDR_W), .NUM_REGS(NREG), .BYTE_W(BW)) i_wide_reg_bridge (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_val(live_val),
      .wr_allow(wr_allow), .per_wdata(per_wdata), .per_wstb(per_wstb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_live(input int r, input logic [15:0] v);
      live_val[r*16 +: 16] = v;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [BW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [BW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [BW-1:0]   rd;
      logic [BW-1:0]   tmp;
      logic [15:0]     prev_pw;
      repeat (3) @(negedge clk);
      chk("R8 strobe", 32'(per_wstb), 0);
      chk("R8 wdata", 32'(per_wdata), 0);
      rst_n = 1'b1;
      bus_read(3'd1, rd);
      chk("R8 hold zero", 32'(rd), 0);
      tmp = '0;
      prev_pw = '0;

      for (int r = 0; r < NREG; r++) begin
         for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            logic [7:0]  hh, ll;
            bit          ok;
            v = (16'hA5C3 ^ 16'(r * 16'h1357)) + 16'(k * 16'h0F21);
            set_live(r, v);
            bus_read(3'(2*r), rd);
            chk("R1 low read", 32'(rd), 32'(v[7:0]));
            tmp = v[15:8];
            set_live(r, v ^ 16'hFF00);
            bus_read(3'(2*r+1), rd);
            chk("R2 R3 high read from hold", 32'(rd), 32'(tmp));
            hh = 8'(k * 37 + r * 11 + 5);
            ll = 8'(k * 53 + r * 7 + 1);
            bus_write(3'(2*r+1), hh);
            chk("R4 no strobe on high write", 32'(per_wstb), 0);
            tmp = hh;
            bus_read(3'(2*r+1), rd);
            chk("R4 high write loads hold", 32'(rd), 32'(hh));
            ok = k[0];
            wr_allow = '1;
            wr_allow[r] = ok;
            bus_write(3'(2*r), ll);
            if (ok) begin
               chk("R5 R10 strobe onehot", 32'(per_wstb), 32'(1 << r));
               chk("R5 word data", 32'(per_wdata), 32'({hh, ll}));
               prev_pw = {hh, ll};
               @(negedge clk);
               chk("R5 single cycle", 32'(per_wstb), 0);
            end else begin
               chk("R6 no strobe", 32'(per_wstb), 0);
               chk("R6 data kept", 32'(per_wdata), 32'(prev_pw));
               bus_read(3'(2*r+1), rd);
               chk("R6 hold kept", 32'(rd), 32'(tmp));
            end
            wr_allow = '1;
         end
      end

      set_live(0, 16'h1122);
      set_live(1, 16'h3344);
      bus_read(3'd0, rd);
      bus_read(3'd2, rd);
      bus_read(3'd1, rd);
      chk("R7 shared hold read", 32'(rd), 32'h33);
      bus_write(3'd1, 8'h77);
      bus_write(3'd2, 8'h5A);
      chk("R7 shared hold write strobe", 32'(per_wstb), 32'b010);
      chk("R7 shared hold write data", 32'(per_wdata), 32'h775A);
      prev_pw = 16'h775A;
      tmp = 8'h77;

      bus_read(3'd6, rd);
      chk("R9 unmapped low read", 32'(rd), 0);
      bus_read(3'd7, rd);
      chk("R9 unmapped high read", 32'(rd), 0);
      bus_write(3'd7, 8'h99);
      chk("R9 unmapped high write no strobe", 32'(per_wstb), 0);
      bus_read(3'd1, rd);
      chk("R9 unmapped write leaves hold", 32'(rd), 32'(tmp));
      bus_write(3'd6, 8'h42);
      chk("R9 unmapped low write no strobe", 32'(per_wstb), 0);
      chk("R9 unmapped low write data kept", 32'(per_wdata), 32'(prev_pw));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule